// File: doc/BRIEF.md
# Coincident Edge Sync Pulse Generator

Two output clocks, A and C, are divided from one fast clock. Each runs at its own integer divide ratio. The block drives both divided clocks and an active-low sync line. The sync line goes low shortly before the next rising edge that A and C share. A downstream consumer can then prepare for that alignment point before it happens. This matters most when neither clock frequency is a whole multiple of the other.

The low pulse is measured in periods of the faster bank. When the ratios differ, the pulse lasts exactly one faster-bank period and ends at the shared edge. When the two ratios are equal, every rising edge is shared. The pulse then repeats each period and covers the low phase of the common clock.

Reset puts both dividers at a common origin. A change of either effective ratio starts a one-cycle realignment slot, and both dividers restart together after it.

Top module: `coinc_sync_gen`

## Requirements
- R1: While rst_ni is low, qa_o and qc_o are 0 and sync_no is 1. This holds at once, with no clock edge needed.
- R2: A bank with effective ratio N has a period of N fast-clock cycles. Counting from the first running cycle, the bank output is 1 for the first ceil(N/2) cycles of each period and 0 for the rest. Both banks start running in the same cycle, so their first rising edges coincide.
- R3: A ratio input value of 0 or 1 is treated as 2.
- R4: Let the effective ratios differ, with m the smaller ratio and L their least common multiple. Counting cycles t from the first running cycle, sync_no is 0 exactly when (t mod L) >= L - m.
- R5: Let the effective ratios be equal, with value N. Then sync_no is 0 exactly when (t mod N) >= N - floor(N/2).
- R6: The first clock edge after reset starts one realignment slot, and so does any edge at which an effective ratio differs from the one in use. During that slot qa_o and qc_o are 0 and sync_no is 1. The new ratios are in use from the next cycle, which counts as t = 0.
- R7: Each rise of sync_no in running state falls in the same cycle as a rising edge shared by qa_o and qc_o.
- R8: A change of a raw ratio input that leaves its effective value the same does not realign. The outputs continue their sequence without a break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_a_i | input | DIV_W | Divide ratio of bank A |
| div_c_i | input | DIV_W | Divide ratio of bank C |
| qa_o | output | 1 | Divided clock, bank A |
| qc_o | output | 1 | Divided clock, bank C |
| sync_no | output | 1 | Active-low warning of the next shared rising edge |

## Verification
The hardest case to reach from the ports is a raw ratio change that leaves the effective ratio the same. A correct design shows nothing in that case, so only a long, unbroken check of the sequence across the change can show that no realignment happened. The stimulus runs the 2-to-3 pair partway through its common period. It then writes 1 in place of 2 and keeps checking the same sequence without resetting its cycle count. After that it writes 0 and 1, which is a real change to an equal-ratio pair, and the bench expects a realignment slot.

// File: rtl/csync_pkg.sv
package csync_pkg;
  typedef enum logic {
    PH_ALIGN = 1'b0,
    PH_RUN   = 1'b1
  } phase_e;

  localparam int unsigned NUM_BANK = 2;
  localparam int unsigned BANK_A   = 0;
  localparam int unsigned BANK_C   = 1;
endpackage

// File: rtl/csync_div.sv
module csync_div #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic             q_o
);
  localparam int unsigned EW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic [EW-1:0]    high_len;

  always_comb begin
    if (!run_i || clr_i) begin
      cnt_d = '0;
    end else if (cnt_q == ratio_i - DIV_W'(1)) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // ceil(N/2) cycles high at the start of each period
  assign high_len = ({1'b0, ratio_i} + EW'(1)) >> 1;
  assign q_o      = run_i && ({1'b0, cnt_q} < high_len);
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/csync_win.sv
module csync_win #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             run_i,
  input  logic [DIV_W-1:0] ratio_a_i,
  input  logic [DIV_W-1:0] ratio_c_i,
  input  logic [DIV_W-1:0] cnt_a_i,
  input  logic [DIV_W-1:0] cnt_c_i,
  output logic             sync_no
);
  logic             a_fast;
  logic [DIV_W-1:0] m_fast;
  logic [DIV_W-1:0] n_slow;
  logic [DIV_W-1:0] c_fast;
  logic [DIV_W-1:0] c_slow;
  logic [DIV_W-1:0] lead;
  logic             low;

  assign a_fast = ratio_a_i <= ratio_c_i;
  assign m_fast = a_fast ? ratio_a_i : ratio_c_i;
  assign n_slow = a_fast ? ratio_c_i : ratio_a_i;
  assign c_fast = a_fast ? cnt_a_i : cnt_c_i;
  assign c_slow = a_fast ? cnt_c_i : cnt_a_i;
  assign lead   = n_slow - m_fast;

  always_comb begin
    if (ratio_a_i == ratio_c_i) begin
      // every edge shared: low over the trailing floor(N/2) cycles
      low = cnt_a_i >= (m_fast - (m_fast >> 1));
    end else begin
      // last fast period before slow wraps, with fast wrapping in step
      low = (c_slow >= lead) && (c_fast == c_slow - lead);
    end
  end

  assign sync_no = !(run_i && low);
endmodule

// File: rtl/coinc_sync_gen.sv
module coinc_sync_gen
  import csync_pkg::*;
#(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_a_i,
  input  logic [DIV_W-1:0] div_c_i,
  output logic             qa_o,
  output logic             qc_o,
  output logic             sync_no
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  phase_e           phase_q;
  logic             run;
  logic             restart;
  logic [DIV_W-1:0] eff   [NUM_BANK];
  logic [DIV_W-1:0] cfg_q [NUM_BANK];
  logic [DIV_W-1:0] cnt   [NUM_BANK];
  logic             q     [NUM_BANK];

  assign eff[BANK_A] = (div_a_i < MIN_DIV) ? MIN_DIV : div_a_i;
  assign eff[BANK_C] = (div_c_i < MIN_DIV) ? MIN_DIV : div_c_i;

  assign run     = (phase_q == PH_RUN);
  assign restart = run && ((eff[BANK_A] != cfg_q[BANK_A]) ||
                           (eff[BANK_C] != cfg_q[BANK_C]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ALIGN;
    end else if (!run) begin
      phase_q <= PH_RUN;
    end else if (restart) begin
      phase_q <= PH_ALIGN;
    end
  end

  for (genvar g = 0; g < NUM_BANK; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cfg_q[g] <= MIN_DIV;
      else if (!run) cfg_q[g] <= eff[g];
    end

    csync_div #(.DIV_W(DIV_W)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .clr_i  (restart),
      .ratio_i(cfg_q[g]),
      .cnt_o  (cnt[g]),
      .q_o    (q[g])
    );
  end

  csync_win #(.DIV_W(DIV_W)) u_win (
    .run_i    (run),
    .ratio_a_i(cfg_q[BANK_A]),
    .ratio_c_i(cfg_q[BANK_C]),
    .cnt_a_i  (cnt[BANK_A]),
    .cnt_c_i  (cnt[BANK_C]),
    .sync_no  (sync_no)
  );

  assign qa_o = q[BANK_A];
  assign qc_o = q[BANK_C];
endmodule

// File: rtl/coinc_sync_gen_chk.sv
module coinc_sync_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic qa_i,
  input logic qc_i,
  input logic sync_ni
);
  // R6
  align_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!qa_i && !qc_i && sync_ni));

  // R2
  start_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (qa_i && qc_i));

  // R7
  release_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sync_ni) && run_i && $past(run_i)) |-> ($rose(qa_i) && $rose(qc_i)));

  // R4
  low_only_running_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_ni |-> run_i);

  // R5
  fall_on_transition_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sync_ni) && $past(run_i)) |-> ((qa_i != $past(qa_i)) || (qc_i != $past(qc_i))));
endmodule

bind coinc_sync_gen coinc_sync_gen_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .run_i  (run),
  .qa_i   (qa_o),
  .qc_i   (qc_o),
  .sync_ni(sync_no)
);

// File: tb/coinc_sync_gen_bench.sv
module coinc_sync_gen_bench;
  localparam int DIV_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [DIV_W-1:0] div_a = '0;
  logic [DIV_W-1:0] div_c = '0;
  logic qa, qc, sync_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  coinc_sync_gen #(.DIV_W(DIV_W)) u_coinc_sync_gen (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .div_a_i(div_a),
    .div_c_i(div_c),
    .qa_o   (qa),
    .qc_o   (qc),
    .sync_no(sync_n)
  );

  // {ratio A, ratio C, common period, low window}
  localparam int NROW = 10;
  localparam int VEC [NROW][4] = '{
    '{2, 2, 2, 1},
    '{2, 4, 4, 2},
    '{6, 2, 6, 2},
    '{2, 3, 6, 2},
    '{8, 2, 8, 2},
    '{3, 4, 12, 3},
    '{2, 12, 12, 2},
    '{3, 3, 3, 1},
    '{5, 7, 35, 5},
    '{4, 4, 4, 2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // walk t0..t0+n-1 from a negedge; ends on a negedge
  task automatic run_seq(input int na, input int nc, input int per, input int win,
                         input int t0, input int n, input string sreq);
    int prev_s = 1;
    for (int t = t0; t < t0 + n; t++) begin
      int ea = ((t % na) < (na + 1) / 2) ? 1 : 0;
      int ec = ((t % nc) < (nc + 1) / 2) ? 1 : 0;
      int es = ((t % per) >= per - win) ? 0 : 1;
      chk(int'(qa) == ea, "R2 qa", int'(qa), ea);
      chk(int'(qc) == ec, "R2 qc", int'(qc), ec);
      chk(int'(sync_n) == es, sreq, int'(sync_n), es);
      if (t > t0 && (t % per) == 0)
        chk(prev_s == 0 && sync_n && qa && qc, "R7 shared edge",
            {prev_s[0], sync_n, qa, qc}, 4'b0111);
      prev_s = int'(sync_n);
      @(negedge clk);
    end
  endtask

  task automatic chk_align(input string req);
    chk(!qa && !qc && sync_n, req, {qa, qc, sync_n}, 3'b001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    div_a = DIV_W'(VEC[0][0]);
    div_c = DIV_W'(VEC[0][1]);
    repeat (3) @(negedge clk);
    chk_align("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    // table walk: first row starts directly after reset release
    for (int r = 0; r < NROW; r++) begin
      if (r > 0) begin
        div_a = DIV_W'(VEC[r][0]);
        div_c = DIV_W'(VEC[r][1]);
        @(negedge clk);
        chk_align("R6 realign slot");
        @(negedge clk);
      end
      run_seq(VEC[r][0], VEC[r][1], VEC[r][2], VEC[r][3], 0, 2 * VEC[r][2] + 3,
              (VEC[r][0] == VEC[r][1]) ? "R5 equal sync" : "R4 sync window");
    end

    // R8: raw 1 clamps to 2, same as running value; no realign
    div_a = 4'd2; div_c = 4'd3;
    @(negedge clk);
    chk_align("R6 realign slot");
    @(negedge clk);
    run_seq(2, 3, 6, 2, 0, 8, "R4 sync window");
    div_a = 4'd1;
    run_seq(2, 3, 6, 2, 8, 12, "R8 no realign sync");

    // R3: 0 and 1 act as 2, a real change to an equal pair
    div_a = 4'd0; div_c = 4'd1;
    @(negedge clk);
    chk_align("R3 realign on clamp change");
    @(negedge clk);
    run_seq(2, 2, 2, 1, 0, 6, "R3 clamped equal sync");

    // R1: asynchronous reset mid-run
    #3 rst_ni = 1'b0;
    #2 chk_align("R1 async reset");
    @(negedge clk);
    chk_align("R1 held reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule